// File: doc/BRIEF.md
# Bus-Synchronized Master Clock Rate Selector

This block sits in the clock domain of the bus masters and produces a clock-enable that sets their working rate as a fraction of a fast system clock. A 3-bit speed-select input picks either full speed or a divided rate of 1/2, 1/4, 1/8, 1/16 or 1/32. The master logic advances only on cycles where the enable is high. Bus accesses are counted in enabled states, so at 1/4 a four-state access spans sixteen system clocks. Peripheral logic ignores this enable and keeps running on every system clock.

A new selection is not applied when it is presented. It is applied only on a cycle where the bus-cycle-done input is high, so a rate change never lands in the middle of a bus access. When a different ratio is applied, the internal divider restarts from zero. Selecting zero returns the master domain to full speed, and that change also waits for a bus boundary. The block also reports the ratio in effect as a log2 code.

Top module: `mclk_div_sel`

## Requirements
- R1: A synchronous active-high reset sets the ratio code to 0 (full speed) and clears the divider. The enable is high on the first cycle after reset.
- R2: Select encoding: 3'b000 gives code 0 (divide by 1), 001 gives code 1 (/2), 010 gives code 2 (/4), 011 gives code 3 (/8), 100 gives code 4 (/16), 101 gives code 5 (/32). `ratio_log2_o` shows the code in effect.
- R3: Select values 3'b110 and 3'b111 are treated as 3'b101 (code 5, /32).
- R4: While `bus_done_i` is low, changes on `spd_sel_i` have no effect on `ratio_log2_o` or on the enable cadence.
- R5: A selection whose code differs from the one in effect is applied at the clock edge where `bus_done_i` is high. The divider then restarts, so the first enable comes N cycles after that edge (counting the cycle right after the edge as 1), where N = 2^code.
- R6: With code 0, `mce_o` is high on every cycle.
- R7: With a non-zero code, `mce_o` is high for exactly one cycle in every N cycles.
- R8: A `bus_done_i` pulse whose selection decodes to the code already in effect does not restart the divider and does not disturb the cadence.
- R9: Selecting 3'b000 from a divided rate returns to full speed only at a bus boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_sel_i | input | 3 | Requested master speed select |
| bus_done_i | input | 1 | High when the current bus cycle finishes in this clock |
| mce_o | output | 1 | Master-domain clock enable |
| ratio_log2_o | output | 3 | log2 of the divide ratio in effect |

## Verification
The bench measures the gap between enables right after each ratio is applied, and again for the following period. A design that failed to restart its counter would give a short first gap, and an off-by-one divider would give the wrong steady period. It changes the select with the boundary input held low and checks that nothing moves, which catches a design that latches the select straight away. It also pulses the boundary with an unchanged selection in mid-period, and with the 110/111 aliases after /32: a design that restarted on every pulse would push the next enable late. Finally, a reset in mid-run must bring back full speed.

// File: rtl/mclk_div_sel.sv
module mclk_div_sel #(
  parameter int SEL_W    = 3,
  parameter int MAX_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] spd_sel_i,
  input  logic             bus_done_i,
  output logic             mce_o,
  output logic [SEL_W-1:0] ratio_log2_o
);
  localparam int CNT_W = MAX_LOG2;
  localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(MAX_LOG2);

  logic [SEL_W-1:0] code_q, code_req;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   last_cnt;
  logic             apply;

  assign code_req = (spd_sel_i > MAX_CODE) ? MAX_CODE : spd_sel_i;
  assign apply    = bus_done_i && (code_req != code_q);
  assign last_cnt = ((CNT_W+1)'(1) << code_q) - (CNT_W+1)'(1);

  assign mce_o        = (code_q == '0) || ({1'b0, cnt_q} == last_cnt);
  assign ratio_log2_o = code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else if (apply) begin
      code_q <= code_req;
      cnt_q  <= '0;
    end else if (mce_o) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R4, R5: the code moves only on an edge where the boundary input was high
  a_r4_change_at_boundary: assert property (@(posedge clk) disable iff (rst || rst_d)
    (code_q != $past(code_q)) |-> $past(bus_done_i));

  // R6
  a_r6_full_speed_enable: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |-> mce_o);

  // R7: enable pulses in divided mode are one cycle wide
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (code_q != '0 && mce_o && !apply) |=> !mce_o);

  // R5: the divider restarts after a new ratio is applied
  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    apply |=> (cnt_q == '0));

  // R7: the counter never passes the end of its period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} <= last_cnt));
endmodule

// File: tb/tb_mclk_div_sel.sv
module tb_mclk_div_sel;
  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] sel = 0;
  logic       bd  = 0;
  logic       ce;
  logic [2:0] code;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mclk_div_sel dut (.clk(clk), .rst(rst), .spd_sel_i(sel), .bus_done_i(bd),
                    .mce_o(ce), .ratio_log2_o(code));

  localparam int NV = 9;
  localparam logic [2:0] T_SEL [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd6, 3'd0, 3'd7};
  localparam logic [2:0] T_CODE[NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd5, 3'd0, 3'd5};
  localparam int         T_N   [NV] = '{2, 4, 8, 16, 32, 1, 32, 1, 32};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s);
    @(negedge clk); sel = s; bd = 1;
    @(negedge clk); bd = 0;
  endtask

  // counts samples from the current negedge up to and including the enable
  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 80; i++) begin
      n++;
      if (ce) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 code", code, 0);
    check("R1 ce", ce, 1);
    @(negedge clk);
    check("R6 ce", ce, 1);

    for (int v = 0; v < NV; v++) begin
      apply(T_SEL[v]);
      check("R2/R3 code", code, T_CODE[v]);
      measure(n);
      check("R5 first gap", n, T_N[v]);
      @(negedge clk); measure(n);
      check("R7 period", n, T_N[v]);
    end

    // R4: select changes without a boundary are ignored
    apply(3'd2);
    sel = 3'd5;
    measure(n);
    check("R4 gap", n, 4);
    check("R4 code", code, 2);
    @(negedge clk); measure(n);
    check("R4 period", n, 4);

    // R8: same code at a boundary mid-period does not restart
    apply(3'd3);
    @(negedge clk); @(negedge clk);
    sel = 3'd3; bd = 1;
    @(negedge clk); bd = 0;
    measure(n);
    check("R8 gap", n, 5);

    // R8 via alias: 111 while /32 (110) in effect
    apply(3'd6);
    repeat (10) @(negedge clk);
    sel = 3'd7; bd = 1;
    @(negedge clk); bd = 0;
    measure(n);
    check("R8 alias gap", n, 21);

    // R9: 000 waits for a boundary
    apply(3'd4);
    sel = 3'd0;
    repeat (3) @(negedge clk);
    check("R9 held code", code, 4);
    check("R9 held ce", ce, 0);
    apply(3'd0);
    check("R9 code", code, 0);
    check("R9 ce", ce, 1);

    // R1: reset mid-run
    apply(3'd5);
    repeat (5) @(negedge clk);
    rst = 1;
    @(negedge clk); rst = 0;
    check("R1 reset code", code, 0);
    check("R1 reset ce", ce, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule